// File: doc/BRIEF.md
# Dual-Enable Static Memory Model

This block is a synthesizable cycle model of an 8192 x 8 static memory whose controls follow an asynchronous part. It has two chip selects of opposite polarity, an active-low output enable and an active-low write strobe. A fast internal clock samples every control and bus pin. On each edge the block works out which of five modes applies: standby, disabled, output-off, read or write. The high-true select also gates the address and data input latches, so the captured values hold still while the part is in standby.

A write window is open while both selects are active and the write strobe is low. The window can close in three ways: the strobe rises, the low-true select rises, or the high-true select falls. Whichever closes it first, the byte that was sampled in the last open cycle is stored at the address sampled in that same cycle. The read path returns one registered byte per edge, together with a separate drive flag. This stands in for a bidirectional pin. The storage is 128 rows of 64 bytes. The upper address bits pick the row and the lower six bits pick the byte inside it.

Top module: `sram_dual_enable`

## Requirements
- R1: While reset is high, and in the cycle after it, `rdata_valid` is 0 and `rdata` is 0. A write window that is open when reset arrives is dropped and stores nothing.
- R2: When `sel_hi` is 0 (standby), no byte is driven and nothing is written, whatever the levels of `sel_n`, `out_en_n` and `wr_n`.
- R3: When `sel_hi` is 1 and `sel_n` is 1 (disabled), no byte is driven and nothing is written, even with `wr_n` low.
- R4: When both selects are active, `wr_n` is 1 and `out_en_n` is 1, the output is off and no byte is driven.
- R5: When both selects are active, `out_en_n` is 0 and `wr_n` is 1, then one edge later `rdata_valid` is 1 and `rdata` holds the byte at `addr`. Row = `addr[12:6]` and byte-in-row = `addr[5:0]`, so neighbouring addresses across a row boundary are distinct words.
- R6: When both selects are active and `wr_n` is 0, the output is not driven, even with `out_en_n` low.
- R7: A write window closed by `wr_n` rising stores the data sampled in the last open cycle, at the address sampled in that cycle.
- R8: A write window closed by `sel_n` rising stores the same way as R7.
- R9: A write window closed by `sel_hi` falling stores the same way as R7. Address and data values presented during the standby that follows are not captured and are not written.
- R10: If address or data change while a window is open, only the final sampled pair is stored. Earlier addresses in that window keep their contents.
- R11: A read issued on the same edge that commits a write to the same address returns the newly committed byte.
- R12: Whenever `rdata_valid` is 0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select; low means standby and gates the input latches |
| out_en_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 13 | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not driven |
| rdata_valid | output | 1 | Drive flag for `rdata` |

## Verification
A write commit and a read can fall on the same edge. This happens when a late write ends with the write strobe rising while the output enable is already low, so the cycle that closes the window is itself a read. The bench provokes this at the same address that was just written and also at a different address. The scoreboard expects the fresh byte at the written address and the stored byte elsewhere, taken from a reference model that updates its memory only after it has formed the read expectation with forwarding.

// File: rtl/sram_de_pkg.sv
package sram_de_pkg;

    localparam int SRAM_ADDR_W = 13;
    localparam int SRAM_DATA_W = 8;
    localparam int SRAM_COL_W  = 6;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_DISABLED,
        MODE_OUTOFF,
        MODE_READ,
        MODE_WRITE
    } sram_mode_e;

    // Priority: high-true select, then low-true select, then strobe, then OE.
    function automatic sram_mode_e resolve_mode(
        input logic sel_n,
        input logic sel_hi,
        input logic out_en_n,
        input logic wr_n
    );
        if (!sel_hi)        return MODE_STANDBY;
        else if (sel_n)     return MODE_DISABLED;
        else if (!wr_n)     return MODE_WRITE;
        else if (!out_en_n) return MODE_READ;
        else                return MODE_OUTOFF;
    endfunction

endpackage

// File: rtl/sram_de_mode.sv
module sram_de_mode
    import sram_de_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic sel_hi,
    input  logic out_en_n,
    input  logic wr_n,
    output logic rd_en,
    output logic commit
);

    sram_mode_e mode;
    logic       win_open;
    logic       win_q;

    always_comb begin
        mode     = resolve_mode(sel_n, sel_hi, out_en_n, wr_n);
        rd_en    = (mode == MODE_READ);
        win_open = (mode == MODE_WRITE);
        commit   = win_q && !win_open && !rst;
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= 1'b0;
        else     win_q <= win_open;
    end

    AST_WRITE_EXCLUDES_READ: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> !rd_en); // R6

    AST_COMMIT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(sel_hi && !sel_n && !wr_n)); // R7

    AST_NO_COMMIT_OPEN: assert property (@(posedge clk) disable iff (rst)
        (sel_hi && !sel_n && !wr_n) |-> !commit); // R10

endmodule

// File: rtl/sram_de_capture.sv
module sram_de_capture #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (gate) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

    AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !gate |=> $stable(addr_q)); // R9

endmodule

// File: rtl/sram_de_array.sv
module sram_de_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);

    localparam int ROW_W    = ADDR_W - COL_W;
    localparam int ROWS     = 1 << ROW_W;
    localparam int ROW_BITS = DATA_W << COL_W;

    logic [ROW_BITS-1:0] rows [ROWS];

    logic [ROW_W-1:0]  wr_row, rd_row;
    logic [COL_W-1:0]  wr_col, rd_col;
    logic [DATA_W-1:0] rd_word;
    logic              fwd;

    always_comb begin
        wr_row  = wr_addr[ADDR_W-1:COL_W];
        wr_col  = wr_addr[COL_W-1:0];
        rd_row  = rd_addr[ADDR_W-1:COL_W];
        rd_col  = rd_addr[COL_W-1:0];
        rd_word = rows[rd_row][int'(rd_col)*DATA_W +: DATA_W];
        fwd     = commit && (wr_addr == rd_addr);
    end

    always_ff @(posedge clk) begin
        if (commit)
            rows[wr_row][int'(wr_col)*DATA_W +: DATA_W] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= rd_en;
            if (!rd_en)   dout <= '0;
            else if (fwd) dout <= wr_data;
            else          dout <= rd_word;
        end
    end

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !dvalid |-> (dout == '0)); // R12

endmodule

// File: rtl/sram_dual_enable.sv
module sram_dual_enable
    import sram_de_pkg::*;
#(
    parameter int ADDR_W = SRAM_ADDR_W,
    parameter int DATA_W = SRAM_DATA_W,
    parameter int COL_W  = SRAM_COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              out_en_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    logic              rd_en;
    logic              commit;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;

    sram_de_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .sel_n    (sel_n),
        .sel_hi   (sel_hi),
        .out_en_n (out_en_n),
        .wr_n     (wr_n),
        .rd_en    (rd_en),
        .commit   (commit)
    );

    sram_de_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .gate    (sel_hi),
        .addr_in (addr),
        .data_in (wdata),
        .addr_q  (lat_addr),
        .data_q  (lat_data)
    );

    sram_de_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .wr_addr (lat_addr),
        .wr_data (lat_data),
        .rd_en   (rd_en),
        .rd_addr (addr),
        .dout    (rdata),
        .dvalid  (rdata_valid)
    );

    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> $past(sel_hi && !sel_n && !out_en_n && wr_n)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rdata_valid); // R1

    AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $past(!sel_hi) |-> !rdata_valid); // R2

endmodule

// File: tb/test_sram_dual_enable.sv
module test_sram_dual_enable;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1, sel_hi = 1'b0, out_en_n = 1'b1, wr_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sram_dual_enable i_sram_dual_enable (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel_hi(sel_hi),
        .out_en_n(out_en_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    typedef struct {
        logic       drv;
        logic [7:0] dat;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // Reference model state
    logic [7:0]  mem_m [int];
    logic        win_m = 1'b0;
    logic [12:0] la_m = '0;
    logic [7:0]  ld_m = '0;

    task automatic step(input logic s_n, input logic s_hi, input logic o_n,
                        input logic w_n, input logic [12:0] a,
                        input logic [7:0] d, input string tag);
        exp_t e;
        logic win_now, cmt, rd;
        @(negedge clk);
        #1;
        sel_n = s_n; sel_hi = s_hi; out_en_n = o_n; wr_n = w_n;
        addr = a; wdata = d;
        win_now = s_hi && !s_n && !w_n;
        cmt     = win_m && !win_now && !rst;
        rd      = s_hi && !s_n && !o_n && w_n;
        e.tag = tag;
        e.drv = rst ? 1'b0 : rd;
        if (rst || !rd)            e.dat = 8'h00;
        else if (cmt && la_m == a) e.dat = ld_m;
        else                       e.dat = mem_m[int'(a)];
        if (cmt) mem_m[int'(la_m)] = ld_m;
        if (rst) begin
            win_m = 1'b0; la_m = '0; ld_m = '0;
        end else begin
            win_m = win_now;
            if (s_hi) begin la_m = a; ld_m = d; end
        end
        sb_q.push_back(e);
    endtask

    task automatic rd_at(input logic [12:0] a, input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b1, a, 8'h00, tag);
    endtask

    task automatic wr_at(input logic [12:0] a, input logic [7:0] d, input string tag);
        step(1'b0, 1'b1, 1'b1, 1'b0, a, d, tag);
        step(1'b0, 1'b1, 1'b1, 1'b1, a, d, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'b1, 1'b1, 1'b1, 13'h0, 8'h00, tag);
    endtask

    // Monitor: compares each registered result one edge after its stimulus
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (rdata_valid !== e.drv || rdata !== e.dat) begin
                failures++;
                $display("FAIL %s: got valid=%0b data=%02h expected valid=%0b data=%02h",
                         e.tag, rdata_valid, rdata, e.drv, e.dat);
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(1'b1, 1'b0, 1'b1, 1'b1, 13'h0, 8'h00, "R1 reset");
        rst = 1'b0;
        idle("R1 after reset");

        // R7 + R11: late write closed by strobe while OE already low
        step(1'b0, 1'b1, 1'b0, 1'b0, 13'h0000, 8'h5A, "R6 write with OE low");
        step(1'b0, 1'b1, 1'b0, 1'b0, 13'h0000, 8'h5A, "R6 write with OE low");
        rd_at(13'h0000, "R11 same-edge forward");
        rd_at(13'h0000, "R7 late write stored");

        // R8: early write closed by low-true select rising
        step(1'b0, 1'b1, 1'b1, 1'b0, 13'h1FFF, 8'hC3, "R8 window");
        step(1'b1, 1'b1, 1'b1, 1'b0, 13'h1FFF, 8'h00, "R3 disabled close");
        rd_at(13'h1FFF, "R8 select-closed write");

        // R9: closed by high-true select falling; standby bus ignored
        wr_at(13'h0842, 8'h11, "R9 setup");
        step(1'b0, 1'b1, 1'b1, 1'b0, 13'h0841, 8'h3C, "R9 window");
        step(1'b0, 1'b0, 1'b1, 1'b0, 13'h0842, 8'hFF, "R2 standby close");
        step(1'b0, 1'b0, 1'b0, 1'b1, 13'h0842, 8'hEE, "R2 standby no drive");
        rd_at(13'h0841, "R9 stored at pre-standby address");
        rd_at(13'h0842, "R9 standby bus not stored");

        // R2: strobe low in standby writes nothing
        repeat (2) step(1'b0, 1'b0, 1'b0, 1'b0, 13'h0842, 8'h77, "R2 standby strobe");
        idle("R2 idle");
        rd_at(13'h0842, "R2 unchanged");

        // R3: disabled with strobe low
        repeat (2) step(1'b1, 1'b1, 1'b0, 1'b0, 13'h0842, 8'h66, "R3 disabled strobe");
        idle("R3 idle");
        rd_at(13'h0842, "R3 unchanged");

        // R4: output off
        step(1'b0, 1'b1, 1'b1, 1'b1, 13'h0842, 8'h00, "R4 output off");
        step(1'b0, 1'b1, 1'b1, 1'b1, 13'h0000, 8'h00, "R4 output off");

        // R5: row boundary distinct words
        wr_at(13'h003F, 8'hA1, "R5 setup");
        wr_at(13'h0040, 8'hB2, "R5 setup");
        rd_at(13'h003F, "R5 last byte of row");
        rd_at(13'h0040, "R5 first byte of next row");
        rd_at(13'h1FFF, "R5 top address");

        // R10: address/data change inside one window
        wr_at(13'h0100, 8'hAA, "R10 setup");
        wr_at(13'h0101, 8'h55, "R10 setup");
        step(1'b0, 1'b1, 1'b1, 1'b0, 13'h0100, 8'h01, "R10 window");
        step(1'b0, 1'b1, 1'b1, 1'b0, 13'h0101, 8'h02, "R10 window");
        step(1'b0, 1'b1, 1'b0, 1'b1, 13'h0100, 8'h00, "R11 other address no forward");
        rd_at(13'h0100, "R10 earlier address kept");
        rd_at(13'h0101, "R10 final pair stored");

        // R1: reset during an open window drops it
        wr_at(13'h0200, 8'h10, "R1 setup");
        step(1'b0, 1'b1, 1'b1, 1'b0, 13'h0200, 8'h99, "R1 window");
        rst = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b0, 13'h0200, 8'h99, "R1 reset in window");
        step(1'b0, 1'b1, 1'b1, 1'b1, 13'h0200, 8'h99, "R1 close under reset");
        rst = 1'b0;
        idle("R1 after reset");
        rd_at(13'h0200, "R1 dropped write");
        idle("R12 quiet bus");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hang expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule